// File: doc/BRIEF.md
# Link Error-Ratio Health Monitor

One instance of this block sits beside each serial link receiver. It watches two things: the share of received packets that fail their CRC, and whether the link's receive/transmit handshake is still alive. From these it derives a two-bit health code, consumed by a fault aggregator that collects status from every link of a node.

Packets are counted in observation windows of a programmable number of packets. When a window closes, the error count is compared with the programmable threshold using only a shift and a multiply, with no divider. The window counters then restart. Independently, a timer measures how long the handshake has been quiet. If the quiet time reaches a programmable limit, the link is reported broken. It is released only after the handshake comes back and a complete clean window has then been received.

Top module: `link_health_mon`

## Requirements
- R1: After reset the status output reads 00 (normal).
- R2: The status output only ever carries 00 (normal), 01 (sick) or 10 (broken); the code 11 never appears.
- R3: A window closes on the accepted packet (pktValid high) that brings the window's packet count to windowLen, with windowLen of 0 acting as 1. A crcErr pulse is counted only in a cycle where pktValid is also high.
- R4: At window close the link is sick when errors × 2^ERR_SHIFT is greater than errThreshold × packets, and normal otherwise. Equality counts as normal; with ERR_SHIFT = 8 the threshold is in units of 1/256.
- R5: The status changes only at a window close or on handshake timeout; between these it holds. Every window is judged on its own packets only.
- R6: The status becomes broken in the cycle after hsTimeout consecutive clock edges sample hsAlive low. A shorter quiet period has no effect.
- R7: Broken overrides sick: a sick link whose handshake times out reports 10.
- R8: While the link is broken, packets are not counted. The link leaves broken only after hsAlive has been sampled high and a later window closes clean. A window that closes over threshold keeps it broken.
- R9: Leaving broken always leads to normal, never straight to sick. A new handshake timeout during recovery restarts the recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | One-cycle strobe per received packet |
| crcErr | input | 1 | CRC failure for the packet strobed in the same cycle |
| hsAlive | input | 1 | High while handshake activity is seen |
| errThreshold | input | THR_W | Error-ratio threshold, in units of 2^-ERR_SHIFT |
| windowLen | input | WIN_W | Packets per observation window |
| hsTimeout | input | TMO_W | Quiet cycles before the link is declared broken |
| linkStatus | output | 2 | 00 normal, 01 sick, 10 broken |

## Verification
The bench builds the block with WIN_W = 6, TMO_W = 6, THR_W = 8 and ERR_SHIFT = 8. With these values, windows of four to eight packets and timeouts of five cycles are enough to land exactly on the ratio boundary in both directions: equal products, a zero threshold and the full-scale threshold. They also allow a timeout to be raised during recovery many times within a short run. The narrow counters also bring the saturating quiet timer within reach.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

  typedef enum logic [1:0] {
    LINK_OK   = 2'b00,
    LINK_SICK = 2'b01,
    LINK_DOWN = 2'b10
  } linkCode_e;

  typedef enum logic [1:0] {
    ST_RUN     = 2'b00,
    ST_DOWN    = 2'b01,
    ST_RECOVER = 2'b10
  } monState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic clear;
  } dpCtrl_t;

endpackage

// File: rtl/lhm_datapath.sv
module lhm_datapath
  import lhm_pkg::*;
#(
  parameter int WIN_W     = 16,
  parameter int THR_W     = 8,
  parameter int ERR_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic             pktValid,
  input  logic             crcErr,
  input  logic [WIN_W-1:0] windowLen,
  input  logic [THR_W-1:0] errThreshold,
  output logic             windowDone,
  output logic             overLimit
);

  localparam int CNT_W  = WIN_W + 1;
  localparam int WIDE_W = (THR_W > ERR_SHIFT) ? THR_W : ERR_SHIFT;
  localparam int PROD_W = CNT_W + WIDE_W + 1;

  logic [WIN_W-1:0]  pktCount, errCount;
  logic [CNT_W-1:0]  pktNext, errNext;
  logic [PROD_W-1:0] errScaled, limitProd;
  logic              accept;

  assign accept  = dpCtrl.countEn && pktValid;
  assign pktNext = {1'b0, pktCount} + CNT_W'(1);
  assign errNext = {1'b0, errCount} + CNT_W'(crcErr);

  // window closes when the incremented count reaches the length (0 acts as 1)
  assign windowDone = accept && (pktNext >= {1'b0, windowLen});

  // ratio test without division: errors * 2^k against threshold * packets
  assign errScaled = PROD_W'(errNext) << ERR_SHIFT;
  assign limitProd = PROD_W'(errThreshold) * PROD_W'(pktNext);
  assign overLimit = errScaled > limitProd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktCount <= '0;
      errCount <= '0;
    end else if (dpCtrl.clear || windowDone) begin
      pktCount <= '0;
      errCount <= '0;
    end else if (accept) begin
      pktCount <= pktNext[WIN_W-1:0];
      errCount <= errNext[WIN_W-1:0];
    end
  end

endmodule

// File: rtl/lhm_ctrl.sv
module lhm_ctrl
  import lhm_pkg::*;
#(
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsAlive,
  input  logic [TMO_W-1:0] hsTimeout,
  input  logic             windowDone,
  input  logic             overLimit,
  output dpCtrl_t          dpCtrl,
  output linkCode_e        linkStatus
);

  monState_e        state;
  logic             sickFlag;
  logic [TMO_W-1:0] idleCnt;
  logic [TMO_W:0]   idleNext;
  logic             timeoutHit;

  assign idleNext   = {1'b0, idleCnt} + (TMO_W+1)'(1);
  assign timeoutHit = !hsAlive && (idleNext >= {1'b0, hsTimeout});

  // quiet-period timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN)             idleCnt <= '0;
    else if (hsAlive)      idleCnt <= '0;
    else if (idleCnt != '1) idleCnt <= idleNext[TMO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RUN;
      sickFlag <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (timeoutHit) begin
            state    <= ST_DOWN;
            sickFlag <= 1'b0;
          end else if (windowDone) begin
            sickFlag <= overLimit;
          end
        end
        ST_DOWN: begin
          if (hsAlive) state <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (timeoutHit)                   state <= ST_DOWN;
          else if (windowDone && !overLimit) begin
            state    <= ST_RUN;
            sickFlag <= 1'b0;
          end
        end
        default: state <= ST_DOWN;
      endcase
    end
  end

  always_comb begin
    dpCtrl.countEn = (state != ST_DOWN);
    dpCtrl.clear   = (state == ST_DOWN) || timeoutHit;
  end

  always_comb begin
    if (state != ST_RUN) linkStatus = LINK_DOWN;
    else if (sickFlag)   linkStatus = LINK_SICK;
    else                 linkStatus = LINK_OK;
  end

endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
  import lhm_pkg::*;
#(
  parameter int WIN_W     = 16,
  parameter int THR_W     = 8,
  parameter int ERR_SHIFT = 8,
  parameter int TMO_W     = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pktValid,
  input  logic             crcErr,
  input  logic             hsAlive,
  input  logic [THR_W-1:0] errThreshold,
  input  logic [WIN_W-1:0] windowLen,
  input  logic [TMO_W-1:0] hsTimeout,
  output logic [1:0]       linkStatus
);

  dpCtrl_t   dpCtrl;
  logic      windowDone, overLimit;
  linkCode_e statusCode;

  lhm_datapath #(
    .WIN_W(WIN_W), .THR_W(THR_W), .ERR_SHIFT(ERR_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl),
    .pktValid(pktValid), .crcErr(crcErr),
    .windowLen(windowLen), .errThreshold(errThreshold),
    .windowDone(windowDone), .overLimit(overLimit)
  );

  lhm_ctrl #(
    .TMO_W(TMO_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hsAlive(hsAlive), .hsTimeout(hsTimeout),
    .windowDone(windowDone), .overLimit(overLimit),
    .dpCtrl(dpCtrl), .linkStatus(statusCode)
  );

  assign linkStatus = statusCode;

endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
  parameter int TMO_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             pktValid,
  input logic             hsAlive,
  input logic [TMO_W-1:0] hsTimeout,
  input logic [1:0]       linkStatus
);

  logic [TMO_W-1:0] lowRun;
  logic [TMO_W:0]   lowNext;
  assign lowNext = {1'b0, lowRun} + (TMO_W+1)'(1);

  always_ff @(posedge clk) begin
    if (!rstN)              lowRun <= '0;
    else if (hsAlive)       lowRun <= '0;
    else if (lowRun != '1)  lowRun <= lowNext[TMO_W-1:0];
  end

  p_no_code3_r2: assert property (@(posedge clk) disable iff (!rstN)
    linkStatus != 2'b11);

  p_timeout_broken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!hsAlive && lowNext >= {1'b0, hsTimeout}) |=> linkStatus == 2'b10);

  p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hsAlive && !pktValid) |=> $stable(linkStatus));

  p_broken_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (linkStatus == 2'b10 && !pktValid) |=> linkStatus == 2'b10);

  p_exit_normal_r9: assert property (@(posedge clk) disable iff (!rstN)
    linkStatus == 2'b10 |=> linkStatus != 2'b01);

endmodule

bind link_health_mon lhm_checker #(.TMO_W(TMO_W)) u_lhm_checker (
  .clk(clk), .rstN(rstN), .pktValid(pktValid), .hsAlive(hsAlive),
  .hsTimeout(hsTimeout), .linkStatus(linkStatus)
);

// File: tb/test_link_health_mon.sv
`timescale 1ns/1ps
module test_link_health_mon;

  localparam int WIN_W = 6;
  localparam int THR_W = 8;
  localparam int ERR_SHIFT = 8;
  localparam int TMO_W = 6;

  localparam logic [1:0] S_OK   = 2'b00;
  localparam logic [1:0] S_SICK = 2'b01;
  localparam logic [1:0] S_DOWN = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pktValid = 1'b0, crcErr = 1'b0, hsAlive = 1'b1;
  logic [THR_W-1:0] errThreshold = '0;
  logic [WIN_W-1:0] windowLen = '0;
  logic [TMO_W-1:0] hsTimeout = '1;
  logic [1:0] linkStatus;

  int numChecks = 0;
  int numFails = 0;
  logic [1:0] expQ[$];
  string tagQ[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_health_mon #(
    .WIN_W(WIN_W), .THR_W(THR_W), .ERR_SHIFT(ERR_SHIFT), .TMO_W(TMO_W)
  ) i_link_health_mon (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .crcErr(crcErr),
    .hsAlive(hsAlive), .errThreshold(errThreshold), .windowLen(windowLen),
    .hsTimeout(hsTimeout), .linkStatus(linkStatus)
  );

  // monitor: compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        numChecks++;
        if (linkStatus !== e) begin
          numFails++;
          $display("FAIL %s: linkStatus=%b expected=%b", t, linkStatus, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectStatus(input logic [1:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic sendPkt(input logic err);
    pktValid = 1'b1;
    crcErr = err;
    step();
    pktValid = 1'b0;
    crcErr = 1'b0;
  endtask

  // n packets, first e errored, optional idle gap after each
  task automatic runWindow(input int n, input int e, input bit gap);
    for (int i = 0; i < n; i++) begin
      sendPkt(i < e);
      if (gap && i != n - 1) step();
    end
  endtask

  function automatic logic [1:0] ratioVerdict(input int n, input int e);
    return ((e * (1 << ERR_SHIFT)) > (int'(errThreshold) * n)) ? S_SICK : S_OK;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      numFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    expectStatus(S_OK, "R1 reset state");
    step();

    // R4 equality boundary: 1/8 error with threshold 32/256
    windowLen = 8; errThreshold = 32;
    runWindow(8, 1, 1'b1);
    expectStatus(ratioVerdict(8, 1), "R4 ratio equal to threshold is normal");
    step();
    runWindow(8, 2, 1'b0);
    expectStatus(ratioVerdict(8, 2), "R4 ratio above threshold is sick");
    step();

    // R5 holds mid-window, next window judged alone
    runWindow(4, 0, 1'b1);
    expectStatus(S_SICK, "R5 status held mid-window");
    runWindow(4, 0, 1'b0);
    expectStatus(S_OK, "R5 clean window after sick clears");
    step();

    // R4 zero threshold
    errThreshold = 0;
    runWindow(8, 0, 1'b0);
    expectStatus(ratioVerdict(8, 0), "R4 zero threshold, no errors");
    runWindow(8, 1, 1'b0);
    expectStatus(ratioVerdict(8, 1), "R4 zero threshold, one error");
    runWindow(8, 0, 1'b0);
    expectStatus(S_OK, "R5 recovery to normal");

    // R4 full-scale threshold
    errThreshold = 255; windowLen = 4;
    runWindow(4, 4, 1'b0);
    expectStatus(ratioVerdict(4, 4), "R4 all errored beats 255/256");
    runWindow(4, 3, 1'b0);
    expectStatus(ratioVerdict(4, 3), "R4 three of four under 255/256");

    // R3 window length 0 acts as 1
    errThreshold = 32; windowLen = 0;
    sendPkt(1'b1);
    expectStatus(S_SICK, "R3 length 0 closes on single errored packet");
    sendPkt(1'b0);
    expectStatus(S_OK, "R3 length 0 closes on single clean packet");

    // R3 stray crcErr without pktValid not counted
    windowLen = 4;
    crcErr = 1'b1;
    step(); step(); step();
    crcErr = 1'b0;
    runWindow(4, 0, 1'b0);
    expectStatus(S_OK, "R3 crcErr without pktValid ignored");

    // R7 sick then timeout -> broken
    runWindow(4, 2, 1'b0);
    expectStatus(S_SICK, "R4 sick before timeout");
    hsTimeout = 5;
    hsAlive = 1'b0;
    repeat (4) step();
    expectStatus(S_SICK, "R6 one cycle short of timeout");
    step();
    expectStatus(S_DOWN, "R7 broken overrides sick");

    // R8 packets while broken ignored
    runWindow(4, 0, 1'b0);
    expectStatus(S_DOWN, "R8 clean window while quiet stays broken");
    hsAlive = 1'b1;
    step();
    expectStatus(S_DOWN, "R8 handshake back, still broken");
    runWindow(4, 2, 1'b0);
    expectStatus(S_DOWN, "R8 errored window keeps broken");
    runWindow(4, 0, 1'b1);
    expectStatus(S_OK, "R9 clean window releases to normal");

    // R6 short quiet period
    hsAlive = 1'b0;
    repeat (4) step();
    hsAlive = 1'b1;
    step();
    expectStatus(S_OK, "R6 short quiet gap has no effect");
    runWindow(4, 0, 1'b0);
    expectStatus(S_OK, "R6 still normal after short gap");

    // R9 timeout during recovery restarts it
    hsAlive = 1'b0;
    repeat (5) step();
    expectStatus(S_DOWN, "R6 timeout after five quiet cycles");
    hsAlive = 1'b1;
    step();
    hsAlive = 1'b0;
    repeat (5) step();
    runWindow(4, 0, 1'b0);
    expectStatus(S_DOWN, "R9 timeout during recovery restarts it");
    hsAlive = 1'b1;
    step();
    runWindow(4, 0, 1'b0);
    expectStatus(S_OK, "R9 final release to normal");
    expectStatus(S_OK, "R2 no code 11 observed");

    step(); step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end

endmodule